// File: doc/BRIEF.md
# Double-Error-Correcting Byte Memory Codec

This block protects byte-wide memory with a half-rate linear code whose codewords are 16 bits long and at least 5 bits apart. On the write side it takes a data byte and, in the same cycle, returns a parity byte. The memory stores the data byte unchanged and stores the parity byte in a separate memory at the same address. On the read side the block takes the stored data byte and parity byte. It forms an 8-bit syndrome that depends only on which bits flipped, and it repairs any one or any two flipped bits anywhere in the 16-bit word.

The parity byte is the data byte multiplied by an 8x8 circulant matrix. Because the matrix is circulant, rotating the data and the parity by the same amount gives another codeword. The decoder compares the syndrome with the syndromes of all 136 correctable error patterns. It returns the repaired byte and a 2-bit class, one register stage after the read is presented. A syndrome that matches no correctable pattern is reported as uncorrectable, and the read byte is then passed through unaltered.

Top module: `qc_codec`

## Requirements
- R1: The write path is combinational. Parity bit i is the XOR, over every data bit j that is set, of ROW[(i-j) mod 8], with ROW = 8'b0001_0111 (bits 0, 1, 2 and 4 set). Equivalently, the parity is the XOR of ROW rotated left by j for every set data bit j.
- R2: Every nonzero data byte, taken with its parity byte, gives a 16-bit codeword of weight at least 5.
- R3: While reset is high, dec_valid, dec_data and dec_status are zero. A read presented with rd_en high at a clock edge appears on the outputs after that edge, with dec_valid high. dec_valid is low after any edge at which rd_en was low.
- R4: A read whose data and parity form a codeword returns status 2'b00, with dec_data equal to rd_data.
- R5: Codeword bit b is data bit b for b < 8 and parity bit b-8 for b >= 8. Flipping any one codeword bit returns status 2'b01, with dec_data equal to the original data byte.
- R6: Flipping any two distinct codeword bits returns status 2'b10, with dec_data equal to the original data byte.
- R7: An error that lies only in the parity bits still reports its class (2'b01 or 2'b10), and dec_data equals rd_data.
- R8: A read word at distance 3 or more from every codeword returns status 2'b11, and dec_data equals rd_data. No correction is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 8 | Byte to be written |
| wr_parity | output | 8 | Parity byte for wr_data |
| rd_en | input | 1 | A read word is presented this cycle |
| rd_data | input | 8 | Data byte read from memory |
| rd_parity | input | 8 | Parity byte read from memory |
| dec_valid | output | 1 | Decoded result present |
| dec_data | output | 8 | Repaired data byte |
| dec_status | output | 2 | 00 clean, 01 one bit fixed, 10 two bits fixed, 11 uncorrectable |

## Verification
The encoder is driven with all 256 bytes, and each parity byte is compared with the circulant rule. The minimum codeword weight over those outputs confirms that the chosen row gives distance 5. Every one of the 16 single-bit and 120 two-bit error patterns is applied to several data bytes. This separates correction of data bits from parity-only errors, which must leave the byte untouched. Random words with three or four flipped bits are compared against a nearest-codeword search in the bench. That search tells apart the words that fall within distance two of another codeword from the truly uncorrectable ones that must pass through with status 11.

// File: rtl/qc_pkg.sv
package qc_pkg;

    localparam int DATA_W = 8;
    localparam int CW_W   = 2 * DATA_W;
    localparam int NPAIR  = CW_W * CW_W;

    // first row of the circulant parity matrix (bits 0,1,2,4)
    localparam logic [DATA_W-1:0] ROW = 8'b0001_0111;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIX1  = 2'b01,
        ST_FIX2  = 2'b10,
        ST_FAIL  = 2'b11
    } status_e;

    typedef struct packed {
        logic [DATA_W-1:0] par;
        logic [DATA_W-1:0] dat;
    } cword_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        status_e           status;
    } dec_out_t;

    function automatic logic [DATA_W-1:0] encode(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] p;
        p = '0;
        for (int i = 0; i < DATA_W; i++) begin
            for (int j = 0; j < DATA_W; j++) begin
                p[i] = p[i] ^ (d[j] & ROW[(i - j + DATA_W) % DATA_W]);
            end
        end
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] syndrome_of(input cword_t w);
        return encode(w.dat) ^ w.par;
    endfunction

endpackage

// File: rtl/qc_encoder.sv
module qc_encoder
    import qc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] parity_o
);

    assign parity_o = encode(data_i);

endmodule

// File: rtl/qc_error_lookup.sv
module qc_error_lookup
    import qc_pkg::*;
(
    input  logic [DATA_W-1:0] syn_i,
    output logic [CW_W-1:0]   err_o,
    output status_e           cls_o
);

    logic [NPAIR-1:0] hit;
    logic [CW_W-1:0]  masked [NPAIR];

    for (genvar i = 0; i < CW_W; i++) begin : g_row
        for (genvar j = 0; j < CW_W; j++) begin : g_col
            if (j >= i) begin : g_pat
                localparam logic [CW_W-1:0] PAT =
                    (CW_W'(1) << i) | (CW_W'(1) << j);
                localparam logic [DATA_W-1:0] SYN = syndrome_of(cword_t'(PAT));
                assign hit[i*CW_W+j]    = (syn_i == SYN);
                assign masked[i*CW_W+j] = hit[i*CW_W+j] ? PAT : '0;
            end else begin : g_none
                assign hit[i*CW_W+j]    = 1'b0;
                assign masked[i*CW_W+j] = '0;
            end
        end
    end

    always_comb begin
        err_o = '0;
        for (int k = 0; k < NPAIR; k++) begin
            err_o = err_o | masked[k];
        end
    end

    always_comb begin
        if (syn_i == '0)
            cls_o = ST_CLEAN;
        else if (hit == '0)
            cls_o = ST_FAIL;
        else if ($countones(err_o) == 1)
            cls_o = ST_FIX1;
        else
            cls_o = ST_FIX2;
    end

    // R6: distinct correctable patterns never share a syndrome
    always_comb begin
        p_unique_hit_r6: assert ($onehot0(hit))
            else $error("two correctable patterns share one syndrome");
    end

endmodule

// File: rtl/qc_codec.sv
module qc_codec
    import qc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] wr_parity,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] rd_parity,
    output logic              dec_valid,
    output logic [DATA_W-1:0] dec_data,
    output logic [1:0]        dec_status
);

    logic [DATA_W-1:0] recomputed;
    logic [DATA_W-1:0] syndrome;
    logic [CW_W-1:0]   err;
    status_e           cls;
    dec_out_t          nxt, q;

    qc_encoder u_wenc (
        .data_i   (wr_data),
        .parity_o (wr_parity)
    );

    qc_encoder u_renc (
        .data_i   (rd_data),
        .parity_o (recomputed)
    );

    assign syndrome = recomputed ^ rd_parity;

    qc_error_lookup u_lookup (
        .syn_i (syndrome),
        .err_o (err),
        .cls_o (cls)
    );

    always_comb begin
        nxt.valid  = rd_en;
        nxt.status = cls;
        nxt.data   = (cls == ST_FAIL) ? rd_data : (rd_data ^ err[DATA_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{valid: 1'b0, data: '0, status: ST_CLEAN};
        end else begin
            q <= nxt;
        end
    end

    assign dec_valid  = q.valid;
    assign dec_data   = q.data;
    assign dec_status = q.status;

    // R3: one result per presented read, one cycle later
    p_valid_follows_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> dec_valid);
    p_valid_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !dec_valid);

    // R4: a clean word passes through unchanged
    p_clean_passthru_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_status == 2'b00) |-> dec_data == $past(rd_data));

    // R5: single fix changes at most one data bit
    p_fix1_weight_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_status == 2'b01) |->
            $countones(dec_data ^ $past(rd_data)) <= 1);

    // R6: double fix changes at most two data bits
    p_fix2_weight_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_status == 2'b10) |->
            $countones(dec_data ^ $past(rd_data)) <= 2);

    // R8: no correction when uncorrectable
    p_fail_passthru_r8: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_status == 2'b11) |-> dec_data == $past(rd_data));

endmodule

// File: tb/tb_qc_codec.sv
module tb_qc_codec;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] ROW_T = 8'b0001_0111;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] wr_data;
    logic [7:0] wr_parity;
    logic       rd_en;
    logic [7:0] rd_data;
    logic [7:0] rd_parity;
    logic       dec_valid;
    logic [7:0] dec_data;
    logic [1:0] dec_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [7:0] ptab [256];

    qc_codec dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_parity(wr_parity),
        .rd_en(rd_en), .rd_data(rd_data), .rd_parity(rd_parity),
        .dec_valid(dec_valid), .dec_data(dec_data), .dec_status(dec_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
        logic [7:0] r;
        r = v;
        for (int k = 0; k < n; k++) r = {r[6:0], r[7]};
        return r;
    endfunction

    function automatic logic [7:0] ref_parity(input logic [7:0] d);
        logic [7:0] p;
        p = '0;
        for (int j = 0; j < 8; j++) if (d[j]) p = p ^ rotl(ROW_T, j);
        return p;
    endfunction

    function automatic int weight16(input logic [15:0] v);
        int w;
        w = 0;
        for (int k = 0; k < 16; k++) if (v[k]) w++;
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // nearest-codeword search as reference decoder
    task automatic ref_decode(input logic [7:0] d, input logic [7:0] p,
                              output logic [7:0] od, output logic [1:0] os);
        int best;
        int bi;
        best = 99;
        bi = 0;
        for (int c = 0; c < 256; c++) begin
            int w;
            w = weight16({ptab[c], 8'(c)} ^ {p, d});
            if (w < best) begin
                best = w;
                bi = c;
            end
        end
        if (best <= 2) begin
            od = 8'(bi);
            os = 2'(best);
        end else begin
            od = d;
            os = 2'b11;
        end
    endtask

    task automatic do_read(input string tag, input logic [7:0] d,
                           input logic [7:0] p);
        logic [7:0] ed;
        logic [1:0] es;
        ref_decode(d, p, ed, es);
        rd_en = 1'b1;
        rd_data = d;
        rd_parity = p;
        @(negedge clk);
        check({tag, " valid"}, 32'(dec_valid), 32'd1);
        check({tag, " status"}, 32'(dec_status), 32'(es));
        check({tag, " data"}, 32'(dec_data), 32'(ed));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0] bytes [4];
        int minw;
        bytes[0] = 8'h00; bytes[1] = 8'hFF; bytes[2] = 8'hA5; bytes[3] = 8'h3C;
        for (int c = 0; c < 256; c++) ptab[c] = ref_parity(8'(c));

        rst = 1'b1; rd_en = 1'b0; rd_data = '0; rd_parity = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check("R3 reset valid", 32'(dec_valid), 32'd0);
        check("R3 reset data", 32'(dec_data), 32'd0);
        check("R3 reset status", 32'(dec_status), 32'd0);
        rst = 1'b0;

        // R1 encoder over all bytes, R2 minimum distance from DUT outputs
        minw = 99;
        for (int c = 0; c < 256; c++) begin
            wr_data = 8'(c);
            #1;
            check("R1 parity", 32'(wr_parity), 32'(ptab[c]));
            if (c != 0 && weight16({wr_parity, 8'(c)}) < minw)
                minw = weight16({wr_parity, 8'(c)});
        end
        check("R2 min distance", 32'(minw >= 5), 32'd1);

        @(negedge clk);
        // R4 clean words
        for (int b = 0; b < 4; b++)
            do_read("R4 clean", bytes[b], ptab[bytes[b]]);

        // R5 single, R7 parity-only single
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 16; i++) begin
                logic [15:0] cw;
                cw = {ptab[bytes[b]], bytes[b]} ^ (16'd1 << i);
                do_read(i < 8 ? "R5 single" : "R7 parity single", cw[7:0], cw[15:8]);
                check("R5 single data", 32'(dec_data), 32'(bytes[b]));
                check("R5 single status", 32'(dec_status), 32'd1);
            end

        // R6 double, R7 parity-only double
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 16; i++)
                for (int j = i + 1; j < 16; j++) begin
                    logic [15:0] cw;
                    cw = {ptab[bytes[b]], bytes[b]} ^ (16'd1 << i) ^ (16'd1 << j);
                    do_read(i >= 8 ? "R7 parity double" : "R6 double", cw[7:0], cw[15:8]);
                    check("R6 double data", 32'(dec_data), 32'(bytes[b]));
                    check("R6 double status", 32'(dec_status), 32'd2);
                end

        // R8 three and four bit errors against nearest-codeword search
        for (int t = 0; t < 400; t++) begin
            logic [15:0] e;
            logic [7:0] d;
            int nb;
            d = 8'($urandom_range(0, 255));
            nb = (t % 2 == 0) ? 3 : 4;
            e = '0;
            while (weight16(e) < nb) e = e | (16'd1 << $urandom_range(0, 15));
            e = e ^ {ptab[d], d};
            do_read("R8 heavy", e[7:0], e[15:8]);
        end

        // R3 valid drops after an idle cycle
        rd_en = 1'b0;
        @(negedge clk);
        check("R3 idle valid", 32'(dec_valid), 32'd0);

        done = 1;
        finish_run();
    end

endmodule